// File: doc/BRIEF.md
# Debug Event Status Register

This block keeps a 32-bit word of sticky debug flags for a processor core. Every cycle the core may present single-cycle pulses for debug events: an unconditional event, instruction completion, a taken branch, a taken interrupt, a taken trap, four instruction address matches, and read or write matches on two data address comparators. Each pulse that passes its qualifier sets its own flag. The flag stays set until software clears it.

The data address flags are qualified by a two-bit mode field per comparator. Mode bit 1 enables read matches and mode bit 0 enables write matches. An imprecise-event summary flag records events that are raised while debug interrupts are masked under internal debug mode. It also records faulted data compares under external-only debug mode. A two-bit reset-cause field reports a hard reset until software acknowledges it. Software clears flags by writing ones. The word can be read at any time.

Bit numbering is MSB-first: document bit n is `status[31-n]`.

Top module: `dbg_evt_status`

## Requirements
- R1: While `rst_n` is low and after its release, `status` equals 32'h1000_0000. All flags are 0 and the reset-cause field (bits 2:3) holds 01.
- R2: A pulse on `ev_uncond`, `ev_icmp`, `ev_brt`, `ev_irpt` or `ev_trap` sets bit 1, 4, 5, 6 or 7 respectively (`status[30]`, `[27]`, `[26]`, `[25]`, `[24]`) at the next rising edge.
- R3: A pulse on `ev_iac[k]`, k = 0..3, sets bit 8+k (`status[23-k]`) at the next rising edge.
- R4: A pulse on `ev_dac_rd[0]` sets bit 12 (`status[19]`) only when `dac1_mode` is 2'b10 or 2'b11. A pulse on `ev_dac_wr[0]` sets bit 13 (`status[18]`) only when `dac1_mode` is 2'b01 or 2'b11. Otherwise the pulse has no effect.
- R5: Comparator 2 uses `dac2_mode` under the same rule. A read match sets bit 14 (`status[17]`) and a write match sets bit 15 (`status[16]`).
- R6: Bit 0 (`status[31]`) is set when `dbg_int_en`=0, `int_dbg_mode`=1, and any flag among bits 1 and 4..15 is set by a qualified event in the same cycle.
- R7: Bit 0 is also set by a `dac_err` pulse when `ext_dbg_mode`=1 and `int_dbg_mode`=0. In any other mode combination, `dac_err` alone does not set bit 0.
- R8: Flags are sticky. A bit at 1 stays at 1 until a cycle with `sw_wr_en`=1 and a 1 in that position of `sw_wr_data`. That cycle clears the bit at the next edge.
- R9: When a set and a software clear hit the same bit in one cycle, the bit ends at 1.
- R10: Writing 1 to bit 3 (`status[28]`) returns the reset field to 00. The field only ever reads 00 or 01, and nothing except a hard reset sets it.
- R11: Bits 16..31 (`status[15:0]`) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| ev_uncond | input | 1 | Unconditional debug event pulse |
| ev_icmp | input | 1 | Instruction complete event pulse |
| ev_brt | input | 1 | Branch taken event pulse |
| ev_irpt | input | 1 | Interrupt taken event pulse |
| ev_trap | input | 1 | Trap taken event pulse |
| ev_iac | input | 4 | Instruction address match pulses; index k is comparator k+1 |
| ev_dac_rd | input | 2 | Read-type data address match pulses; index 0 is comparator 1 |
| ev_dac_wr | input | 2 | Write-type data address match pulses; index 0 is comparator 1 |
| dac1_mode | input | 2 | Comparator 1 mode: bit 1 enables reads, bit 0 enables writes |
| dac2_mode | input | 2 | Comparator 2 mode, same encoding |
| dbg_int_en | input | 1 | Debug interrupts enabled (0 = masked) |
| int_dbg_mode | input | 1 | Internal debug mode enable |
| ext_dbg_mode | input | 1 | External debug mode enable |
| dac_err | input | 1 | A data compare on a load or store ended with a bus error |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Write-one-to-clear mask, MSB-first numbering |
| status | output | 32 | Current register contents |

## Verification
The assertions take every event input to be sampled only at rising edges. They place no limit on how pulses overlap or repeat. All event, mode and write inputs may change every cycle, so the properties must hold under any combination. The stimulus changes inputs only at falling edges, so each value is stable across the sampling edge. It draws modes, control bits, event pulses and write masks from `$urandom` with a fixed seed. Set and clear collisions, masked-interrupt windows and the error-only imprecise path all occur often within the run.

// File: rtl/dbg_evt_status.sv
module dbg_evt_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_uncond,
  input  logic         ev_icmp,
  input  logic         ev_brt,
  input  logic         ev_irpt,
  input  logic         ev_trap,
  input  logic [3:0]   ev_iac,
  input  logic [1:0]   ev_dac_rd,
  input  logic [1:0]   ev_dac_wr,
  input  logic [1:0]   dac1_mode,
  input  logic [1:0]   dac2_mode,
  input  logic         dbg_int_en,
  input  logic         int_dbg_mode,
  input  logic         ext_dbg_mode,
  input  logic         dac_err,
  input  logic         sw_wr_en,
  input  logic [W-1:0] sw_wr_data,
  output logic [W-1:0] status
);

  localparam int IMP = W - 1;
  localparam int UNC = W - 2;
  localparam int RC_LO = W - 4;
  localparam int FLAG_LSB = W - 16;
  localparam logic [W-1:0] RST_VAL = W'(1) << RC_LO;

  logic [W-1:0] ev_set, keep_mask, clr;
  logic [15:0]  ev_msb;
  logic         any_ev, imp;

  assign ev_msb = {
    1'b0,
    ev_uncond,
    2'b00,
    ev_icmp, ev_brt, ev_irpt, ev_trap,
    ev_iac[0], ev_iac[1], ev_iac[2], ev_iac[3],
    ev_dac_rd[0] & dac1_mode[1],
    ev_dac_wr[0] & dac1_mode[0],
    ev_dac_rd[1] & dac2_mode[1],
    ev_dac_wr[1] & dac2_mode[0]
  };

  assign any_ev = |ev_msb;

  assign imp = (~dbg_int_en & int_dbg_mode & any_ev)
             | (ext_dbg_mode & ~int_dbg_mode & dac_err);

  always_comb begin
    ev_set = '0;
    ev_set[W-1:FLAG_LSB] = ev_msb;
    ev_set[IMP] = imp;
  end

  always_comb begin
    keep_mask = '0;
    keep_mask[W-1:FLAG_LSB] = '1;
    keep_mask[RC_LO+1] = 1'b0;
  end

  assign clr = sw_wr_en ? sw_wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= RST_VAL;
    else        status <= (status & ~clr & keep_mask) | ev_set;
  end

  logic unused_ok;
  assign unused_ok = ^{UNC};

endmodule

module dbg_evt_status_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ev_uncond,
  input logic [3:0]   ev_iac,
  input logic [1:0]   ev_dac_rd,
  input logic [1:0]   dac1_mode,
  input logic         dbg_int_en,
  input logic         int_dbg_mode,
  input logic         ext_dbg_mode,
  input logic         dac_err,
  input logic         sw_wr_en,
  input logic [W-1:0] sw_wr_data,
  input logic [W-1:0] status
);

  logic [W-1:0] kept;
  assign kept = status & ~(sw_wr_en ? sw_wr_data : '0);

  p_reset_val_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> status == (W'(1) << (W-4)));

  p_uncond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uncond |=> status[W-2]);

  p_iac1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_iac[0] |=> status[W-9]);

  p_dac1_rd_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac1_mode[1] && !status[W-13]) |=> !status[W-13]);

  p_dac1_rd_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dac_rd[0] && dac1_mode[1]) |=> status[W-13]);

  p_masked_imp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_int_en && int_dbg_mode && ev_uncond) |=> status[W-1]);

  p_err_imp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dbg_mode && !int_dbg_mode && dac_err) |=> status[W-1]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(kept)) == $past(kept)));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_iac[0] && sw_wr_en && sw_wr_data[W-9]) |=> status[W-9]);

  p_rc_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !status[W-3]);

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[W-17:0] == '0);

endmodule

bind dbg_evt_status dbg_evt_status_chk #(.W(W)) chk_i (.*);

// File: tb/dbg_evt_status_tb.sv
`timescale 1ns/1ps
module dbg_evt_status_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_uncond = 0, ev_icmp = 0, ev_brt = 0, ev_irpt = 0, ev_trap = 0;
  logic [3:0]  ev_iac = '0;
  logic [1:0]  ev_dac_rd = '0, ev_dac_wr = '0, dac1_mode = '0, dac2_mode = '0;
  logic        dbg_int_en = 1, int_dbg_mode = 0, ext_dbg_mode = 0, dac_err = 0;
  logic        sw_wr_en = 0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] status;

  int checks = 0, fails = 0;
  logic [31:0] exp_s;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_evt_status dut_i (.*);

  function automatic logic [31:0] bitn(int n);
    return 32'h8000_0000 >> n;
  endfunction

  function automatic logic [31:0] model(logic [31:0] s);
    logic [31:0] nx, hit;
    nx = s;
    if (sw_wr_en) nx = nx & ~sw_wr_data;
    nx = nx & 32'hDFFF_0000;
    hit = '0;
    if (ev_uncond) hit |= bitn(1);
    if (ev_icmp)   hit |= bitn(4);
    if (ev_brt)    hit |= bitn(5);
    if (ev_irpt)   hit |= bitn(6);
    if (ev_trap)   hit |= bitn(7);
    for (int k = 0; k < 4; k++) if (ev_iac[k]) hit |= bitn(8 + k);
    if (ev_dac_rd[0] && (dac1_mode == 2'b10 || dac1_mode == 2'b11)) hit |= bitn(12);
    if (ev_dac_wr[0] && (dac1_mode == 2'b01 || dac1_mode == 2'b11)) hit |= bitn(13);
    if (ev_dac_rd[1] && (dac2_mode == 2'b10 || dac2_mode == 2'b11)) hit |= bitn(14);
    if (ev_dac_wr[1] && (dac2_mode == 2'b01 || dac2_mode == 2'b11)) hit |= bitn(15);
    if (!dbg_int_en && int_dbg_mode && hit != 0) hit |= bitn(0);
    if (ext_dbg_mode && !int_dbg_mode && dac_err) hit |= bitn(0);
    return nx | hit;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    {ev_uncond, ev_icmp, ev_brt, ev_irpt, ev_trap} = '0;
    ev_iac = '0; ev_dac_rd = '0; ev_dac_wr = '0; dac_err = 0;
    sw_wr_en = 0; sw_wr_data = '0;
  endtask

  task automatic tick(string req);
    exp_s = model(exp_s);
    @(posedge clk);
    @(negedge clk);
    chk(req, status, exp_s);
    idle();
  endtask

  task automatic hard_reset();
    rst_n = 0;
    @(negedge clk);
    chk("R1 in reset", status, 32'h1000_0000);
    rst_n = 1;
    exp_s = 32'h1000_0000;
    @(negedge clk);
    chk("R1 after release", status, 32'h1000_0000);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_s = 32'h1000_0000;
    @(negedge clk);
    hard_reset();

    ev_uncond = 1; tick("R2 uncond");
    chk("R2 uncond literal", status, 32'h5000_0000);
    ev_icmp = 1; ev_brt = 1; ev_irpt = 1; ev_trap = 1; tick("R2 ctl events");
    ev_iac = 4'b1010; tick("R3 iac 2,4");
    ev_iac = 4'b0101; tick("R3 iac 1,3");
    sw_wr_en = 1; sw_wr_data = 32'h4F00_0000; tick("R8 w1c");
    chk("R8 w1c literal", status, 32'h10F0_0000);
    tick("R8 sticky hold");

    sw_wr_en = 1; sw_wr_data = 32'h2000_0000; tick("R10 write bit2 no effect");
    sw_wr_en = 1; sw_wr_data = 32'hFFFF_FFFF; tick("R10 clear all");
    chk("R10 field zero", status, 32'h0000_0000);

    dac1_mode = 2'b01; ev_dac_rd[0] = 1; tick("R4 rd blocked");
    chk("R4 rd blocked literal", status, 32'h0);
    dac1_mode = 2'b10; ev_dac_wr[0] = 1; tick("R4 wr blocked");
    dac1_mode = 2'b10; ev_dac_rd[0] = 1; tick("R4 rd pass");
    chk("R4 rd pass literal", status, 32'h0008_0000);
    dac1_mode = 2'b11; ev_dac_wr[0] = 1; tick("R4 wr pass");
    dac2_mode = 2'b01; ev_dac_rd[1] = 1; tick("R5 rd blocked");
    dac2_mode = 2'b00; ev_dac_wr[1] = 1; tick("R5 wr blocked");
    dac2_mode = 2'b11; ev_dac_rd[1] = 1; ev_dac_wr[1] = 1; tick("R5 both pass");
    chk("R5 literal", status, 32'h000F_0000);

    sw_wr_en = 1; sw_wr_data = 32'h0080_0000; ev_iac[0] = 1; tick("R9 set wins");
    chk("R9 literal", status, 32'h008F_0000);

    dbg_int_en = 0; int_dbg_mode = 1; dac1_mode = 2'b00; ev_dac_rd[0] = 1;
    tick("R6 blocked event no imprecise");
    ev_trap = 1; tick("R6 imprecise");
    chk("R6 literal", status, 32'h818F_0000);
    sw_wr_en = 1; sw_wr_data = 32'h8000_0000; tick("R8 clear imprecise");
    dbg_int_en = 1; ext_dbg_mode = 1; int_dbg_mode = 1; dac_err = 1; tick("R7 err blocked");
    int_dbg_mode = 0; dac_err = 1; tick("R7 err imprecise");
    chk("R7 literal", status, 32'h818F_0000);

    hard_reset();

    for (int i = 0; i < 3000; i++) begin
      ev_uncond = ($urandom % 8) == 0;
      ev_icmp   = ($urandom % 6) == 0;
      ev_brt    = ($urandom % 6) == 0;
      ev_irpt   = ($urandom % 8) == 0;
      ev_trap   = ($urandom % 8) == 0;
      for (int k = 0; k < 4; k++) ev_iac[k] = ($urandom % 7) == 0;
      ev_dac_rd = 2'($urandom); ev_dac_wr = 2'($urandom);
      dac1_mode = 2'($urandom); dac2_mode = 2'($urandom);
      dbg_int_en = $urandom % 2; int_dbg_mode = $urandom % 2;
      ext_dbg_mode = $urandom % 2; dac_err = ($urandom % 4) == 0;
      sw_wr_en = ($urandom % 3) == 0; sw_wr_data = $urandom;
      if (i % 500 == 250) begin idle(); hard_reset(); end
      else tick("R11 random vs model");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule